// File: doc/BRIEF.md
# Synchronized Petri-Net Subnet Controller

This block runs one state-machine subnet of a decomposed interpreted Petri net as a Moore controller with its own local clock. Exactly one place of the subnet is marked at any time. That place is held as a minimum-length binary code in a register of D flip-flops. Next-state logic is built from place and transition conjunctions. An output decoder, addressed by the place code, drives the output variables that this subnet owns. Each place i has a forward transition to place (i+1) mod N_PLACE, guarded by `guard_i[i]`. Places selected by `SKIP_MASK` also have a bypass transition to place (i+2) mod N_PLACE, guarded by `guard_i[N_PLACE+i]`.

Some forward transitions are shared with other subnets; `SHARE_MASK` selects them. While the input place of a shared transition is marked, the subnet raises a synchronization flag for that place. Peer subnets run on clocks unrelated to this one, so their flags are retimed through a two-stage register chain before they take part in any fire condition. A shared transition fires only when every peer reports its own input place of that transition as marked. Code 0 is the place holding the initial marking, or the macroplace standing for it. The pins carry no data stream, so all of them are plain level signals with no valid/ready handshake.

Top module: `pnsc_subnet`

## Requirements
- R1: The place register is $clog2(N_PLACE) bits wide, the code on `place_o` equals the index of the marked place, and it never exceeds N_PLACE-1.
- R2: A synchronous active-high `rst` loads code 0 on the next clock edge; `out_o` then shows the output word of place 0, and `sync_o` has bit 0 set only if transition 0 is shared.
- R3: With place i marked and its forward transition enabled (`guard_i[i]`=1, and for a shared transition every peer flag for i seen as 1), the code becomes (i+1) mod N_PLACE on the next edge.
- R4: When no transition leaving the marked place is enabled, the code keeps its value.
- R5: A shared forward transition from place i does not fire while any peer flag `peer_flag_i[k*N_PLACE+i]`, as seen after retiming, is 0.
- R6: If the forward and the bypass transition of the marked place are both enabled, the forward transition (the lower index) wins.
- R7: From a place in SKIP_MASK with only the bypass enabled (`guard_i[N_PLACE+i]`=1, forward disabled), the code becomes (i+2) mod N_PLACE; for places outside SKIP_MASK, `guard_i[N_PLACE+i]` has no effect.
- R8: `out_o` equals the N_OUT-bit word `OUT_TABLE[p*N_OUT +: N_OUT]` of the marked place p.
- R9: `sync_o[i]` is 1 exactly when place i is marked and SHARE_MASK[i] is 1; all other bits are 0.
- R10: A change of a peer flag first influences a fire decision at the third local clock edge after it is applied; the first two edges after the change still use the old value.
- R11: When two instances exchange flags on unrelated clocks, a shared transition fires in one instance only while the peer's input place is marked or has just been marked within the retiming delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock of this subnet |
| rst | input | 1 | Synchronous active-high reset to place code 0 |
| guard_i | input | 2*N_PLACE | Guards: low half forward transitions, high half bypass transitions |
| peer_flag_i | input | N_PEER*N_PLACE | Synchronization flags from peers, peer k in bits k*N_PLACE+i |
| out_o | output | N_OUT | Output variables decoded from the marked place |
| place_o | output | $clog2(N_PLACE) | Binary code of the marked place |
| sync_o | output | N_PLACE | Synchronization flags for places feeding shared transitions |

## Verification
Two functions can fall in the same cycle and meet in the next-state selection. The first is the competition between the forward and bypass transitions of one place. The second is a peer flag change that lands while the shared transition's local guard is already high. The bench provokes the first case directly with both guards raised, and many more times under seeded random guards. It provokes the second by raising the peer flags while waiting in a shared place and counting the edges until the move. A bench model applies the forward-wins rule and the two-edge retiming delay, and every cycle its result is compared with the place code and outputs. A pair of instances on 20 ns and 27 ns clocks then fire the shared transition against each other, and every firing is judged against the time the peer was last seen in its input place.

// File: rtl/pnsc_pkg.sv
package pnsc_pkg;
  // Successor of place idx after stepping k places around a ring of n places.
  function automatic int unsigned ring_step(input int unsigned idx,
                                            input int unsigned k,
                                            input int unsigned n);
    return (idx + k) % n;
  endfunction
endpackage

// File: rtl/pnsc_sync.sv
module pnsc_sync #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] safe_q;

  // Retiming chain, deliberately without reset: it only carries peer levels.
  always_ff @(posedge clk) begin
    meta_q <= d;
    safe_q <= meta_q;
  end

  assign q = safe_q;

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst)
    q == $past(d, 2)); // R10
endmodule

// File: rtl/pnsc_fire.sv
module pnsc_fire
  import pnsc_pkg::*;
#(
  parameter int unsigned N_PLACE    = 4,
  parameter int unsigned N_PEER     = 2,
  parameter logic [N_PLACE-1:0] SHARE_MASK = 4'b1010,
  parameter logic [N_PLACE-1:0] SKIP_MASK  = 4'b0101,
  localparam int unsigned CW      = (N_PLACE > 1) ? $clog2(N_PLACE) : 1,
  localparam int unsigned N_GUARD = 2 * N_PLACE,
  localparam int unsigned N_PFLAG = N_PEER * N_PLACE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CW-1:0]      place_q,
  input  logic [N_GUARD-1:0] guard,
  input  logic [N_PFLAG-1:0] peer_s,
  output logic [CW-1:0]      place_d,
  output logic [N_PLACE-1:0] ring_fire,
  output logic [N_PLACE-1:0] skip_fire
);
  logic [N_PLACE-1:0] marked;
  logic [N_PLACE-1:0] peer_ok;
  logic [N_PLACE-1:0] ring_en;
  logic [N_PLACE-1:0] skip_en;
  logic [N_PLACE-1:0] hold_term;

  for (genvar i = 0; i < N_PLACE; i++) begin : g_place
    // Place conjunction from the literals of the binary code.
    assign marked[i] = (place_q == CW'(i));

    if (SHARE_MASK[i]) begin : g_shared
      logic [N_PEER-1:0] flags;
      for (genvar k = 0; k < N_PEER; k++) begin : g_peer
        assign flags[k] = peer_s[k*N_PLACE + i];
      end
      assign peer_ok[i] = &flags;

      AST_SHARED_WAIT: assert property (@(posedge clk) disable iff (rst)
        (marked[i] && !peer_ok[i] && !(SKIP_MASK[i] && guard[N_PLACE+i]))
        |=> (place_q == CW'(i))); // R5
    end else begin : g_local
      assign peer_ok[i] = 1'b1;
    end

    assign ring_en[i]   = marked[i] & guard[i] & peer_ok[i];
    assign skip_en[i]   = marked[i] & SKIP_MASK[i] & guard[N_PLACE+i];
    assign hold_term[i] = marked[i] & ~(ring_en[i] | skip_en[i]);

    AST_HOLD_PLACE: assert property (@(posedge clk) disable iff (rst)
      (marked[i] && !guard[i] && !(SKIP_MASK[i] && guard[N_PLACE+i]))
      |=> $stable(place_q)); // R4

    AST_FORWARD_WINS: assert property (@(posedge clk) disable iff (rst)
      (marked[i] && guard[i] && peer_ok[i])
      |=> (place_q == CW'(ring_step(i, 1, N_PLACE)))); // R6

    if (SKIP_MASK[i]) begin : g_skip_chk
      AST_BYPASS_TARGET: assert property (@(posedge clk) disable iff (rst)
        (marked[i] && !guard[i] && guard[N_PLACE+i])
        |=> (place_q == CW'(ring_step(i, 2, N_PLACE)))); // R7
    end
  end

  // Ordered selection: lower transition index first, then hold.
  always_comb begin
    place_d   = '0;
    ring_fire = '0;
    skip_fire = '0;
    for (int i = 0; i < N_PLACE; i++) begin
      if (ring_en[i]) begin
        place_d      = CW'(ring_step(i, 1, N_PLACE));
        ring_fire[i] = 1'b1;
      end else if (skip_en[i]) begin
        place_d      = CW'(ring_step(i, 2, N_PLACE));
        skip_fire[i] = 1'b1;
      end else if (hold_term[i]) begin
        place_d = place_q;
      end
    end
  end

  AST_ONE_FIRE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ring_fire, skip_fire})); // R6
endmodule

// File: rtl/pnsc_decode.sv
module pnsc_decode #(
  parameter int unsigned N_PLACE = 4,
  parameter int unsigned N_OUT   = 3,
  parameter logic [N_PLACE*N_OUT-1:0] OUT_TABLE = '0,
  localparam int unsigned CW = (N_PLACE > 1) ? $clog2(N_PLACE) : 1
) (
  input  logic [CW-1:0]    code,
  output logic [N_OUT-1:0] word
);
  // Code is the address, the owned output variables are the data word.
  always_comb begin
    word = '0;
    for (int p = 0; p < N_PLACE; p++) begin
      if (code == CW'(p)) begin
        word = OUT_TABLE[p*N_OUT +: N_OUT];
      end
    end
  end
endmodule

// File: rtl/pnsc_subnet.sv
module pnsc_subnet #(
  parameter int unsigned N_PLACE = 4,
  parameter int unsigned N_PEER  = 2,
  parameter int unsigned N_OUT   = 3,
  parameter logic [N_PLACE-1:0] SHARE_MASK = 4'b1010,
  parameter logic [N_PLACE-1:0] SKIP_MASK  = 4'b0101,
  parameter logic [N_PLACE*N_OUT-1:0] OUT_TABLE = {3'b110, 3'b100, 3'b010, 3'b001},
  localparam int unsigned CW      = (N_PLACE > 1) ? $clog2(N_PLACE) : 1,
  localparam int unsigned N_GUARD = 2 * N_PLACE,
  localparam int unsigned N_PFLAG = N_PEER * N_PLACE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_GUARD-1:0] guard_i,
  input  logic [N_PFLAG-1:0] peer_flag_i,
  output logic [N_OUT-1:0]   out_o,
  output logic [CW-1:0]      place_o,
  output logic [N_PLACE-1:0] sync_o
);
  localparam logic [N_PLACE-1:0] SYNC_HOME = SHARE_MASK & N_PLACE'(1);

  logic [N_PFLAG-1:0] peer_s;
  logic [CW-1:0]      place_q;
  logic [CW-1:0]      place_d;
  logic [N_PLACE-1:0] ring_fire;
  logic [N_PLACE-1:0] skip_fire;
  logic [N_PLACE-1:0] sync_d;
  logic [N_PLACE-1:0] sync_q;

  pnsc_sync #(.WIDTH(N_PFLAG)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (peer_flag_i),
    .q   (peer_s)
  );

  pnsc_fire #(
    .N_PLACE    (N_PLACE),
    .N_PEER     (N_PEER),
    .SHARE_MASK (SHARE_MASK),
    .SKIP_MASK  (SKIP_MASK)
  ) u_fire (
    .clk       (clk),
    .rst       (rst),
    .place_q   (place_q),
    .guard     (guard_i),
    .peer_s    (peer_s),
    .place_d   (place_d),
    .ring_fire (ring_fire),
    .skip_fire (skip_fire)
  );

  // Flags are formed from the next code so they leave a flop glitch-free.
  for (genvar i = 0; i < N_PLACE; i++) begin : g_flag
    assign sync_d[i] = SHARE_MASK[i] & (place_d == CW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      place_q <= '0;
      sync_q  <= SYNC_HOME;
    end else begin
      place_q <= place_d;
      sync_q  <= sync_d;
    end
  end

  pnsc_decode #(
    .N_PLACE   (N_PLACE),
    .N_OUT     (N_OUT),
    .OUT_TABLE (OUT_TABLE)
  ) u_decode (
    .code (place_q),
    .word (out_o)
  );

  assign place_o = place_q;
  assign sync_o  = sync_q;

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    place_q < CW'(N_PLACE - 1) || place_q == CW'(N_PLACE - 1)); // R1

  AST_RESET_HOME: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (place_q == '0 && sync_q == SYNC_HOME)); // R2

  AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sync_q)); // R9

  for (genvar i = 0; i < N_PLACE; i++) begin : g_flag_chk
    AST_FLAG_MARKED: assert property (@(posedge clk) disable iff (rst)
      sync_q[i] |-> (place_q == CW'(i) && SHARE_MASK[i])); // R9
  end
endmodule

// File: tb/pnsc_subnet_tb_top.sv
`timescale 1ns/100ps
module pnsc_subnet_tb_top;
  localparam int unsigned NP = 4;
  localparam logic [3:0] SHARE = 4'b1010;
  localparam logic [3:0] SKIP  = 4'b0101;

  logic clk = 1'b0;
  logic clk_b = 1'b0;
  logic rst = 1'b1;
  logic rst_p = 1'b1;
  logic [7:0] guard = '0;
  logic [7:0] peer = '0;
  logic [2:0] out_w;
  logic [1:0] place_w;
  logic [3:0] sync_w;

  always #10 clk = ~clk;
  always #13.5 clk_b = ~clk_b;

  pnsc_subnet dut_i (
    .clk (clk), .rst (rst), .guard_i (guard), .peer_flag_i (peer),
    .out_o (out_w), .place_o (place_w), .sync_o (sync_w)
  );

  // Pair of subnets sharing transition 1 on unrelated clocks.
  logic [7:0] ga = '0, gb = '0;
  logic [2:0] oa, ob;
  logic [1:0] pa, pb;
  logic [3:0] sa, sb;

  pnsc_subnet #(.N_PEER(1), .SHARE_MASK(4'b0010), .SKIP_MASK(4'b0000)) sub_a (
    .clk (clk), .rst (rst_p), .guard_i (ga), .peer_flag_i (sb),
    .out_o (oa), .place_o (pa), .sync_o (sa)
  );
  pnsc_subnet #(.N_PEER(1), .SHARE_MASK(4'b0010), .SKIP_MASK(4'b0000)) sub_b (
    .clk (clk_b), .rst (rst_p), .guard_i (gb), .peer_flag_i (sa),
    .out_o (ob), .place_o (pb), .sync_o (sb)
  );

  int n_checks = 0;
  int n_fail = 0;

  function automatic logic [1:0] model_next(input logic [1:0] c,
                                            input logic [7:0] g,
                                            input logic [7:0] ps);
    logic ok;
    ok = SHARE[c] ? (ps[c] & ps[4+c]) : 1'b1;
    if (g[c] && ok) return 2'(c + 1);
    if (SKIP[c] && g[4+c]) return 2'(c + 2);
    return c;
  endfunction

  function automatic logic [2:0] model_out(input logic [1:0] c);
    case (c)
      2'd0: return 3'b001;
      2'd1: return 3'b010;
      2'd2: return 3'b100;
      default: return 3'b110;
    endcase
  endfunction

  logic [1:0] m_code = '0;
  logic [7:0] m_s1 = '0, m_s2 = '0;
  always @(posedge clk) begin
    m_s1 <= peer;
    m_s2 <= m_s1;
    m_code <= rst ? 2'd0 : model_next(m_code, guard, m_s2);
  end

  task automatic check_all(input string tag);
    logic [3:0] exp_sync;
    exp_sync = SHARE & (4'b0001 << m_code);
    n_checks++;
    if (place_w !== m_code || out_w !== model_out(m_code) || sync_w !== exp_sync) begin
      n_fail++;
      $display("FAIL %s: place=%0d out=%b sync=%b expected place=%0d out=%b sync=%b",
               tag, place_w, out_w, sync_w, m_code, model_out(m_code), exp_sync);
    end
  endtask

  task automatic check_val(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] g, input logic [7:0] p, input string tag);
    guard = g;
    peer  = p;
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
  endtask

  // Pair monitoring (R11).
  realtime a_last = 0, b_last = 0;
  bit a_seen = 0, b_seen = 0;
  logic [1:0] a_prev = '0, b_prev = '0;
  int a_fires = 0, b_fires = 0;
  int pair_bad = 0;

  always @(negedge clk) begin
    if (!rst_p) begin
      ga <= 8'($urandom);
      if (pa == 2'd1) begin a_last = $realtime; a_seen = 1; end
      if (a_prev == 2'd1 && pa == 2'd2) begin
        a_fires++;
        if (!(b_seen && ($realtime - b_last) <= 150.0)) begin
          pair_bad++;
          $display("FAIL R11: subnet A fired at %0t, peer last marked at %0t, expected within 150 ns",
                   $realtime, b_last);
        end
      end
      a_prev = pa;
    end
  end

  always @(negedge clk_b) begin
    if (!rst_p) begin
      gb <= 8'($urandom);
      if (pb == 2'd1) begin b_last = $realtime; b_seen = 1; end
      if (b_prev == 2'd1 && pb == 2'd2) begin
        b_fires++;
        if (!(a_seen && ($realtime - a_last) <= 150.0)) begin
          pair_bad++;
          $display("FAIL R11: subnet B fired at %0t, peer last marked at %0t, expected within 150 ns",
                   $realtime, a_last);
        end
      end
      b_prev = pb;
    end
  end

  bit done = 0;
  initial begin
    #(20ns * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_all("R2 reset state");
    check_val("R1 code width", $bits(place_w), 2);
    rst = 1'b0;
    rst_p = 1'b0;

    step(8'h00, 8'h00, "R4 hold with no guard");
    step(8'h01, 8'h00, "R3 forward P0 to P1");
    step(8'h20, 8'h00, "R7 bypass guard ignored at P1");
    step(8'h02, 8'h02, "R5 one peer missing");
    step(8'h02, 8'h02, "R5 still waiting");
    step(8'h02, 8'h22, "R10 first edge after peer change");
    step(8'h02, 8'h22, "R10 second edge after peer change");
    check_val("R10 still in P1", place_w, 1);
    step(8'h02, 8'h22, "R10 third edge fires");
    check_val("R3 shared forward to P2", place_w, 2);
    step(8'h44, 8'h22, "R6 forward beats bypass at P2");
    check_val("R6 landed in P3", place_w, 3);
    step(8'h08, 8'h00, "R5 P3 waits without peers");
    step(8'h08, 8'h88, "R10 P3 peers rising");
    step(8'h08, 8'h88, "R10 P3 peers second edge");
    step(8'h08, 8'h88, "R3 P3 fires to P0");
    step(8'h10, 8'h00, "R7 bypass P0 to P2");
    check_val("R7 landed in P2", place_w, 2);
    step(8'h40, 8'h00, "R7 bypass P2 wraps to P0");
    check_val("R8 output word P0", out_w, 1);
    step(8'h01, 8'h00, "R3 forward again");
    check_val("R9 flag at P1", sync_w, 2);
    rst = 1'b1;
    step(8'hFF, 8'hFF, "R2 reset overrides guards");
    rst = 1'b0;

    for (int n = 0; n < 2000; n++) begin
      logic [7:0] g, p;
      g = 8'($urandom);
      p = ($urandom % 4 == 0) ? 8'($urandom) : peer;
      rst = ($urandom % 97 == 0);
      step(g, p, "R3/R4/R5/R6/R7/R8/R9 random");
      rst = 1'b0;
    end

    check_val("R11 no unsynchronized firing", pair_bad, 0);
    check_val("R11 subnet A fired often", (a_fires >= 5) ? 1 : 0, 1);
    check_val("R11 subnet B fired often", (b_fires >= 5) ? 1 : 0, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule